// File: doc/BRIEF.md
# Average Core Frequency Regulator

This block keeps the long-run average rate of an adaptive core clock at a programmed multiple of a reference clock. It counts rising edges of the monitored core clock over a window of reference cycles. At the end of each window it compares the count with the number a correctly paced clock would have produced, and then nudges a supply threshold code by one step. The code is meant to set the lower trip level of a switched-capacitor converter or the setpoint of a linear regulator.

The loop is deliberately slow. It acts once per window, so it follows the mean frequency and ignores individual ripple cycles.

The monitored clock reaches the block asynchronously. It passes through a flop synchroniser before edge detection, so each of its high and low phases must last at least one and a half reference periods. A fast core clock is therefore presented as a fixed divided tap. The target ratio is given in fixed point to account for that division.

Top module: `afreq_regulator`

## Requirements
- R1: Each rising edge of `core_clk` is counted exactly once, after a two-flop synchroniser. A `core_clk` that never toggles gives a count of zero.
- R2: A window lasts `win_len` reference cycles, and `win_done` pulses high for one cycle after each window. A `win_len` of 0 acts as 1, so `win_done` then stays high every cycle.
- R3: The expected count is floor(`win_len` × `target_ratio` / 16). `target_ratio` is unsigned with 4 fractional bits, so 16 means a ratio of 1.0 and 4 means 0.25.
- R4: `win_offset` holds (counted edges − expected count) as a two's-complement value. It is valid while `win_done` is high and holds its value until the next window ends.
- R5: `vth_code` changes only in the cycle after a `win_done` pulse, and by at most one step.
- R6: A negative offset raises `vth_code` by one. The code saturates at 2^VTH_W−1, which is 63 by default.
- R7: An offset greater than `deadband` lowers `vth_code` by one. The code saturates at 0.
- R8: An offset from 0 to `deadband` inclusive leaves `vth_code` unchanged.
- R9: `settled` rises after `settle_need` consecutive in-band windows. Any out-of-band window clears it.
- R10: In reset (`rst_n` low at a clock edge), `vth_code` takes VTH_INIT (32 by default), and `win_done`, `settled` and `win_offset` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_clk | input | 1 | Monitored core clock tap, asynchronous |
| win_len | input | CNT_W | Window length in reference cycles |
| target_ratio | input | MULT_W | Target edges per reference cycle, 4 fractional bits |
| deadband | input | CNT_W | Allowed positive offset with no correction |
| settle_need | input | SET_W | In-band windows required before `settled` |
| vth_code | output | VTH_W | Supply threshold code |
| win_done | output | 1 | One-cycle pulse at the end of each window |
| win_offset | output | CNT_W+MULT_W+1 | Signed count error of the last window |
| settled | output | 1 | Loop has stayed in band long enough |

## Verification
The bench covers three kinds of cases.

- **Offset arithmetic:** windows whose edge counts sit just below, exactly on, inside and beyond the deadband. An off-by-one in the band test would step the code when it should hold. An inverted sign would drive the supply the wrong way.
- **Code limits:** long runs against both rails. A missing saturation would wrap the code from 63 to 0 or from 0 to 63, which is a full-scale supply jump.
- **Degenerate inputs:** a zero window length, a stalled core clock, and a target change mid-run. Together these show whether window framing, edge counting and the settled streak handle boundary inputs, or whether the streak survives a bad window.

// File: rtl/afr_pkg.sv
// Shared types for the average frequency regulator.
// Assumes nothing beyond IEEE 1800-2017.
package afr_pkg;

    // Correction chosen for one window.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_t;

endpackage

// File: rtl/afr_edge_sync.sv
// Brings an asynchronous clock tap into the reference domain and flags
// each rising edge with a one-cycle pulse.
// Assumes both phases of async_in last at least 1.5 reference periods.
module afr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] chain;

    // Synchroniser stages plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R1: an edge is reported for a single cycle only
    a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/afr_window.sv
// Frames windows of reference cycles, counts synchronised core edges in each
// window and produces the signed error against the fixed-point target.
// Assumes the window length is sampled at the start of each window.
module afr_window #(
    parameter int CNT_W  = 16,
    parameter int MULT_W = 8,
    parameter int FRAC_W = 4,
    parameter int OFF_W  = CNT_W + MULT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rise,
    input  logic [CNT_W-1:0]        win_len,
    input  logic [MULT_W-1:0]       ratio,
    output logic                    done,
    output logic signed [OFF_W-1:0] offset
);

    localparam int PROD_W = CNT_W + MULT_W;

    logic [CNT_W-1:0]  cyc;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  edges;
    logic [CNT_W-1:0]  len_eff;
    logic [CNT_W:0]    final_cnt;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] expect_cnt;
    logic signed [OFF_W-1:0] diff;
    logic              last;

    // Zero length is treated as a one-cycle window.
    assign len_eff    = (win_len == '0) ? CNT_W'(1) : win_len;
    assign last       = (cyc == len_q - 1'b1);
    assign final_cnt  = {1'b0, edges} + (CNT_W+1)'(rise);
    assign prod       = len_q * ratio;
    assign expect_cnt = prod >> FRAC_W;
    assign diff       = $signed({{(OFF_W-CNT_W-1){1'b0}}, final_cnt})
                      - $signed({1'b0, expect_cnt});

    // Window framing, edge accumulation and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= '0;
            len_q  <= len_eff;
            edges  <= '0;
            done   <= 1'b0;
            offset <= '0;
        end else begin
            done <= last;
            if (last) begin
                cyc    <= '0;
                len_q  <= len_eff;
                edges  <= '0;
                offset <= diff;
            end else begin
                cyc   <= cyc + 1'b1;
                edges <= edges + CNT_W'(rise);
            end
        end
    end

    // R2: the cycle index never leaves the window
    a_r2_cyc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cyc < len_q);
    // R2: windows longer than one cycle give isolated done pulses
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && len_q != CNT_W'(1)) |=> !done);
    // R4: the reported error only moves together with a done pulse
    a_r4_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(offset));

endmodule

// File: rtl/afr_stepper.sv
// Turns each window error into a one-step move of the saturating threshold
// code and tracks how many consecutive windows stayed inside the deadband.
// Assumes done is a single-cycle pulse with offset valid alongside it.
module afr_stepper
    import afr_pkg::*;
#(
    parameter int VTH_W    = 6,
    parameter int VTH_INIT = 32,
    parameter int OFF_W    = 25,
    parameter int DB_W     = 16,
    parameter int SET_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done,
    input  logic signed [OFF_W-1:0] offset,
    input  logic [DB_W-1:0]         deadband,
    input  logic [SET_W-1:0]        settle_need,
    output logic [VTH_W-1:0]        vth_code,
    output logic                    settled
);

    localparam logic [VTH_W-1:0] VTH_MAX = '1;
    localparam logic [VTH_W-1:0] VTH_RST = VTH_W'(VTH_INIT);

    logic signed [OFF_W-1:0] band_hi;
    step_dir_t               dir;
    logic [SET_W-1:0]        streak;
    logic [SET_W:0]          streak_inc;
    logic [SET_W-1:0]        streak_next;
    logic                    reached;

    assign band_hi = $signed({{(OFF_W-DB_W){1'b0}}, deadband});

    // Classify the window error.
    always_comb begin
        if (offset < 0)            dir = STEP_UP;
        else if (offset > band_hi) dir = STEP_DOWN;
        else                       dir = STEP_HOLD;
    end

    assign streak_inc  = {1'b0, streak} + 1'b1;
    assign streak_next = streak_inc[SET_W] ? '1 : streak_inc[SET_W-1:0];
    assign reached     = streak_inc >= {1'b0, settle_need};

    // Apply the correction and update the in-band streak once per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vth_code <= VTH_RST;
            streak   <= '0;
            settled  <= 1'b0;
        end else if (done) begin
            unique case (dir)
                STEP_UP: begin
                    if (vth_code != VTH_MAX) vth_code <= vth_code + 1'b1;
                    streak  <= '0;
                    settled <= 1'b0;
                end
                STEP_DOWN: begin
                    if (vth_code != '0) vth_code <= vth_code - 1'b1;
                    streak  <= '0;
                    settled <= 1'b0;
                end
                default: begin
                    streak  <= streak_next;
                    settled <= reached;
                end
            endcase
        end
    end

    // R5: the code is quiet between windows
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(vth_code));
    // R5: never more than one step per update
    a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vth_code == $past(vth_code)) || (vth_code == $past(vth_code) + 1'b1)
        || (vth_code + 1'b1 == $past(vth_code)));
    // R6: a slow window raises the code unless at the top rail
    a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (done && offset < 0 && vth_code != VTH_MAX) |=> vth_code == $past(vth_code) + 1'b1);
    // R7: a fast window lowers the code unless at the bottom rail
    a_r7_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (done && offset > band_hi && vth_code != '0) |=> vth_code + 1'b1 == $past(vth_code));
    // R8: in-band windows leave the code alone
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && offset >= 0 && offset <= band_hi) |=> $stable(vth_code));
    // R9: any out-of-band window drops the settled flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (offset < 0 || offset > band_hi)) |=> !settled);

endmodule

// File: rtl/afreq_regulator.sv
// Top level: counts core clock edges per reference window and steers a
// supply threshold code so the average core rate meets the target ratio.
// Assumes core_clk is a tap slow enough for flop synchronisation.
module afreq_regulator #(
    parameter int CNT_W       = 16,
    parameter int MULT_W      = 8,
    parameter int FRAC_W      = 4,
    parameter int VTH_W       = 6,
    parameter int VTH_INIT    = 32,
    parameter int SET_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int OFF_W      = CNT_W + MULT_W + 1
) (
    input  logic                    clk_ref,
    input  logic                    rst_n,
    input  logic                    core_clk,
    input  logic [CNT_W-1:0]        win_len,
    input  logic [MULT_W-1:0]       target_ratio,
    input  logic [CNT_W-1:0]        deadband,
    input  logic [SET_W-1:0]        settle_need,
    output logic [VTH_W-1:0]        vth_code,
    output logic                    win_done,
    output logic signed [OFF_W-1:0] win_offset,
    output logic                    settled
);

    logic core_rise;

    afr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .async_in (core_clk),
        .rise     (core_rise)
    );

    afr_window #(
        .CNT_W  (CNT_W),
        .MULT_W (MULT_W),
        .FRAC_W (FRAC_W),
        .OFF_W  (OFF_W)
    ) u_win (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .rise    (core_rise),
        .win_len (win_len),
        .ratio   (target_ratio),
        .done    (win_done),
        .offset  (win_offset)
    );

    afr_stepper #(
        .VTH_W    (VTH_W),
        .VTH_INIT (VTH_INIT),
        .OFF_W    (OFF_W),
        .DB_W     (CNT_W),
        .SET_W    (SET_W)
    ) u_step (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .done        (win_done),
        .offset      (win_offset),
        .deadband    (deadband),
        .settle_need (settle_need),
        .vth_code    (vth_code),
        .settled     (settled)
    );

endmodule

// File: tb/tb_afreq_regulator.sv
`timescale 1ns/1ps
module tb_afreq_regulator;

    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic        core_clk = 1'b0;
    logic [15:0] win_len = 16'd64;
    logic [7:0]  target_ratio = 8'd4;
    logic [15:0] deadband = 16'd0;
    logic [7:0]  settle_need = 8'd3;
    logic [5:0]  vth_code;
    logic        win_done;
    logic signed [24:0] win_offset;
    logic        settled;

    int checks = 0;
    int errors = 0;
    int core_h = 2;   // reference cycles per core_clk phase, 0 = stalled

    afreq_regulator dut (
        .clk_ref      (clk_ref),
        .rst_n        (rst_n),
        .core_clk     (core_clk),
        .win_len      (win_len),
        .target_ratio (target_ratio),
        .deadband     (deadband),
        .settle_need  (settle_need),
        .vth_code     (vth_code),
        .win_done     (win_done),
        .win_offset   (win_offset),
        .settled      (settled)
    );

    always #5 clk_ref = ~clk_ref;

    // Core clock tap: restarts its phase in reset, toggles every core_h cycles.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk_ref);
            #1;
            if (!rst_n || core_h == 0) begin
                core_clk = 1'b0;
                ph = 0;
            end else begin
                ph++;
                if (ph >= core_h) begin
                    core_clk = ~core_clk;
                    ph = 0;
                end
            end
        end
    end

    typedef struct packed {
        int h; int m; int mult; int db; int off;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2, 64, 4, 0,  0},   // exact match: hold
        '{2, 64, 5, 0, -4},   // slow: up
        '{2, 64, 3, 2,  4},   // fast beyond band: down
        '{2, 64, 3, 4,  4},   // fast on band edge: hold
        '{3, 60, 3, 0, -1},   // truncated target, one short: up
        '{4, 64, 2, 1,  0},   // slower tap, exact: hold
        '{2, 32, 8, 0, -8}    // short window, slow: up
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk_ref); while (!win_done);
    endtask

    // R10: hold reset for two edges, check reset values, release.
    task automatic do_reset();
        @(negedge clk_ref);
        rst_n = 1'b0;
        repeat (2) @(negedge clk_ref);
        chk(vth_code == 6'd32, "R10 vth reset", vth_code, 32);
        chk(!win_done && !settled, "R10 flags reset", {win_done, settled}, 0);
        chk(win_offset == 0, "R10 offset reset", win_offset, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pre;
        int dir;
        int gap;

        // Table walk: R1, R3, R4, R6, R7, R8 on the second window of each config.
        foreach (VECS[i]) begin
            core_h = VECS[i].h;
            win_len = 16'(VECS[i].m);
            target_ratio = 8'(VECS[i].mult);
            deadband = 16'(VECS[i].db);
            do_reset();
            wait_done();
            wait_done();
            chk(int'(win_offset) == VECS[i].off, "R3 R4 offset", int'(win_offset), VECS[i].off);
            pre = vth_code;
            dir = (VECS[i].off < 0) ? 1 : (VECS[i].off > VECS[i].db) ? -1 : 0;
            @(negedge clk_ref);
            chk(int'(vth_code) == pre + dir,
                dir > 0 ? "R6 raise" : dir < 0 ? "R7 lower" : "R8 hold",
                vth_code, pre + dir);
            chk(!win_done, "R2 single pulse", win_done, 0);
        end

        // R2: window spacing equals win_len.
        core_h = 2; win_len = 16'd64; target_ratio = 8'd4; deadband = 16'd0;
        settle_need = 8'd3;
        do_reset();
        wait_done();
        gap = 0;
        do begin @(negedge clk_ref); gap++; end while (!win_done);
        chk(gap == 64, "R2 window length", gap, 64);

        // R9: settled needs three in-band windows, drops on a bad one.
        do_reset();
        wait_done();
        wait_done();
        @(negedge clk_ref);
        chk(!settled, "R9 not yet settled", settled, 0);
        wait_done();
        wait_done();
        @(negedge clk_ref);
        chk(settled, "R9 settled", settled, 1);
        target_ratio = 8'd5;
        wait_done();
        pre = vth_code;
        @(negedge clk_ref);
        chk(!settled, "R9 cleared", settled, 0);
        chk(int'(vth_code) == pre + 1, "R6 raise after target change", vth_code, pre + 1);

        // R1: stalled core clock counts nothing.
        core_h = 0; win_len = 16'd16; target_ratio = 8'd16;
        do_reset();
        wait_done();
        chk(int'(win_offset) == -16, "R1 stalled clock", int'(win_offset), -16);

        // R6: saturation at the top rail.
        core_h = 2; win_len = 16'd8; target_ratio = 8'd8; deadband = 16'd0;
        do_reset();
        repeat (45) wait_done();
        @(negedge clk_ref);
        chk(vth_code == 6'd63, "R6 top saturation", vth_code, 63);

        // R7: saturation at the bottom rail.
        target_ratio = 8'd0;
        repeat (75) wait_done();
        @(negedge clk_ref);
        chk(vth_code == 6'd0, "R7 bottom saturation", vth_code, 0);

        // R2: zero length behaves as one-cycle windows.
        win_len = 16'd0;
        do_reset();
        wait_done();
        @(negedge clk_ref);
        chk(win_done, "R2 zero length", win_done, 1);
        @(negedge clk_ref);
        chk(win_done, "R2 zero length repeat", win_done, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule